// File: doc/BRIEF.md
# Programmable sum-of-products logic array

This block is the programmable AND-OR plane of a small emulated logic device. Twelve dedicated inputs and ten feedback lines form 22 signals. Each signal enters the array twice, once as itself and once inverted, which gives 44 literal columns. Every row of the array is one product term. A row is the AND of the literals that its configuration bits connect. A flat configuration vector holds one bit per crosspoint.

The rows fall into four groups:
- sum rows, split into ten groups of unequal size, one group per output;
- one enable row per output;
- one global reset row;
- one global preset row.

Each output's OR sum combines only the rows of its own group. The whole evaluation is combinational. The registers, the output polarity and the loading of the configuration vector are left to the surrounding logic.

With the default parameters the array has 132 rows: 120 sum rows, 10 enable rows and 2 global rows. The group sizes rise from 8 to 16 terms toward the middle outputs and fall back to 8, in steps of 2.

Top module: `sop_array`

## Requirements
- R1: Literal column 2*s carries signal s and column 2*s+1 carries its inverse. Signals 0 to 11 are `in_i[0..11]` and signals 12 to 21 are `fb_i[0..9]`.
- R2: Configuration bit `fuse_i[r*44 + c]` connects column c to row r, where a value of 1 means connected.
- R3: A row with no connected column evaluates to 1.
- R4: A row connected to both column 2*s and column 2*s+1 of one signal evaluates to 0, whatever the inputs.
- R5: Rows 0 to 119 are the sum rows, assigned to outputs 0 to 9 in ascending order in groups of 8, 10, 12, 14, 16, 16, 14, 12, 10 and 8 rows.
- R6: `sum_o[k]` is the OR of the rows in group k only. Rows of other groups have no effect on it.
- R7: `oe_o[k]` equals row 120+k.
- R8: `areset_term_o` equals row 130 and `preset_term_o` equals row 131.
- R9: Every output follows its inputs and configuration in the same cycle, and no state is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_i | input | 12 | Dedicated input signals |
| fb_i | input | 10 | Feedback signals from the output cells |
| fuse_i | input | 5808 | Crosspoint configuration, row-major, 1 = connected |
| sum_o | output | 10 | OR sum of each output's own term group |
| oe_o | output | 10 | Per-output enable product term |
| areset_term_o | output | 1 | Global reset product term |
| preset_term_o | output | 1 | Global preset product term |

## Verification
Every result is due in the same cycle as the stimulus that causes it, because no register lies between any input and any output. The bench applies inputs and configuration one time unit after a rising edge. It compares all outputs at the following falling edge against a behavioural model, so every comparison sees a settled combinational result. Directed configurations cover the blank-row, conflicting-pair and group-boundary cases. Random sparse configurations then exercise the full term distribution.

// File: rtl/sop_array_pkg.sv
package sop_array_pkg;

  // Number of sum terms given to output k: a symmetric ramp.
  function automatic int terms_of(input int k, input int n_out,
                                  input int min_t, input int step);
    int idx;
    idx = (k < n_out / 2) ? k : (n_out - 1 - k);
    return min_t + step * idx;
  endfunction

  // First sum row belonging to output k.
  function automatic int first_of(input int k, input int n_out,
                                  input int min_t, input int step);
    int acc;
    acc = 0;
    for (int j = 0; j < k; j++) acc += terms_of(j, n_out, min_t, step);
    return acc;
  endfunction

  function automatic int total_sum_terms(input int n_out,
                                         input int min_t, input int step);
    return first_of(n_out, n_out, min_t, step);
  endfunction

endpackage

// File: rtl/sop_literal_drv.sv
module sop_literal_drv #(
  parameter int N_SIG = 22,
  localparam int N_COL = 2 * N_SIG
) (
  input  logic [N_SIG-1:0] sig_i,
  output logic [N_COL-1:0] lit_o
);
  for (genvar s = 0; s < N_SIG; s++) begin : g_lit
    assign lit_o[2*s]   = sig_i[s];
    assign lit_o[2*s+1] = ~sig_i[s];
  end
endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane #(
  parameter int N_COL = 44,
  parameter int N_ROW = 132,
  localparam int FUSE_W = N_COL * N_ROW
) (
  input  logic [N_COL-1:0]  lit_i,
  input  logic [FUSE_W-1:0] fuse_i,
  output logic [N_ROW-1:0]  pterm_o
);
  // Unconnected columns are forced to 1, so an empty row yields 1
  // and a row holding both polarities of one signal yields 0.
  for (genvar r = 0; r < N_ROW; r++) begin : g_row
    assign pterm_o[r] = &(~fuse_i[r*N_COL +: N_COL] | lit_i);
  end
endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane
  import sop_array_pkg::*;
#(
  parameter int N_OUT     = 10,
  parameter int MIN_TERMS = 8,
  parameter int TERM_STEP = 2,
  localparam int N_SUM = total_sum_terms(N_OUT, MIN_TERMS, TERM_STEP)
) (
  input  logic [N_SUM-1:0] pterm_i,
  output logic [N_OUT-1:0] sum_o
);
  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    localparam int FIRST = first_of(k, N_OUT, MIN_TERMS, TERM_STEP);
    localparam int COUNT = terms_of(k, N_OUT, MIN_TERMS, TERM_STEP);
    assign sum_o[k] = |pterm_i[FIRST +: COUNT];
  end
endmodule

// File: rtl/sop_array.sv
module sop_array
  import sop_array_pkg::*;
#(
  parameter int N_IN      = 12,
  parameter int N_OUT     = 10,
  parameter int MIN_TERMS = 8,
  parameter int TERM_STEP = 2,
  localparam int N_SIG  = N_IN + N_OUT,
  localparam int N_COL  = 2 * N_SIG,
  localparam int N_SUM  = total_sum_terms(N_OUT, MIN_TERMS, TERM_STEP),
  localparam int N_ROW  = N_SUM + N_OUT + 2,
  localparam int FUSE_W = N_ROW * N_COL
) (
  input  logic [N_IN-1:0]   in_i,
  input  logic [N_OUT-1:0]  fb_i,
  input  logic [FUSE_W-1:0] fuse_i,
  output logic [N_OUT-1:0]  sum_o,
  output logic [N_OUT-1:0]  oe_o,
  output logic              areset_term_o,
  output logic              preset_term_o
);
  localparam int ROW_OE = N_SUM;
  localparam int ROW_AR = N_SUM + N_OUT;
  localparam int ROW_SP = ROW_AR + 1;

  logic [N_COL-1:0] lit;
  logic [N_ROW-1:0] pterm;

  sop_literal_drv #(.N_SIG(N_SIG)) u_lit (
    .sig_i ({fb_i, in_i}),
    .lit_o (lit)
  );

  sop_and_plane #(.N_COL(N_COL), .N_ROW(N_ROW)) u_and (
    .lit_i   (lit),
    .fuse_i  (fuse_i),
    .pterm_o (pterm)
  );

  sop_or_plane #(
    .N_OUT(N_OUT), .MIN_TERMS(MIN_TERMS), .TERM_STEP(TERM_STEP)
  ) u_or (
    .pterm_i (pterm[N_SUM-1:0]),
    .sum_o   (sum_o)
  );

  assign oe_o          = pterm[ROW_OE +: N_OUT];
  assign areset_term_o = pterm[ROW_AR];
  assign preset_term_o = pterm[ROW_SP];
endmodule

// File: rtl/sop_array_chk.sv
module sop_array_chk
  import sop_array_pkg::*;
#(
  parameter int N_IN      = 12,
  parameter int N_OUT     = 10,
  parameter int MIN_TERMS = 8,
  parameter int TERM_STEP = 2,
  localparam int N_SIG  = N_IN + N_OUT,
  localparam int N_COL  = 2 * N_SIG,
  localparam int N_SUM  = total_sum_terms(N_OUT, MIN_TERMS, TERM_STEP),
  localparam int N_ROW  = N_SUM + N_OUT + 2,
  localparam int FUSE_W = N_ROW * N_COL
) (
  input logic [N_IN-1:0]   in_i,
  input logic [N_OUT-1:0]  fb_i,
  input logic [FUSE_W-1:0] fuse_i,
  input logic [N_OUT-1:0]  sum_o,
  input logic [N_OUT-1:0]  oe_o,
  input logic              areset_term_o,
  input logic              preset_term_o
);
  localparam int ROW_AR = N_SUM + N_OUT;
  localparam int ROW_SP = ROW_AR + 1;

  logic [N_COL-1:0] one_hot_c0;
  assign one_hot_c0 = {{(N_COL-1){1'b0}}, 1'b1};

  always_comb begin
    for (int k = 0; k < N_OUT; k++) begin
      // R3 / R7: blank enable row gives an asserted enable
      if (fuse_i[(N_SUM+k)*N_COL +: N_COL] == '0)
        a_r7_blank_enable_high: assert (oe_o[k] == 1'b1);
      // R3 / R6: blank first row of a group forces its sum high
      if (fuse_i[first_of(k, N_OUT, MIN_TERMS, TERM_STEP)*N_COL +: N_COL] == '0)
        a_r6_blank_group_row_high: assert (sum_o[k] == 1'b1);
    end
    // R4: both polarities of signal 0 on the preset row force it low
    if (fuse_i[ROW_SP*N_COL] === 1'b1 && fuse_i[ROW_SP*N_COL+1] === 1'b1
        && !$isunknown(fuse_i[ROW_SP*N_COL +: N_COL]) && !$isunknown(in_i))
      a_r4_pair_forces_low: assert (preset_term_o == 1'b0);
    // R8 / R1: reset row holding only column 0 follows in_i[0]
    if (fuse_i[ROW_AR*N_COL +: N_COL] == one_hot_c0 && !$isunknown(in_i))
      a_r8_reset_row_follows: assert (areset_term_o == in_i[0]);
  end
endmodule

bind sop_array sop_array_chk #(
  .N_IN(N_IN), .N_OUT(N_OUT), .MIN_TERMS(MIN_TERMS), .TERM_STEP(TERM_STEP)
) u_chk (
  .in_i          (in_i),
  .fb_i          (fb_i),
  .fuse_i        (fuse_i),
  .sum_o         (sum_o),
  .oe_o          (oe_o),
  .areset_term_o (areset_term_o),
  .preset_term_o (preset_term_o)
);

// File: tb/sop_array_bench.sv
module sop_array_bench;
  localparam int NCOL = 44;
  localparam int NROW = 132;
  localparam int FW   = NCOL * NROW;

  logic clk;
  logic rst_n;
  logic [11:0]   in_i;
  logic [9:0]    fb_i;
  logic [FW-1:0] fuse;
  logic [9:0]    sum_o, oe_o;
  logic          ar_o, sp_o;

  int checks;
  int errors;
  int wd;
  int grp_cnt[10] = '{8, 10, 12, 14, 16, 16, 14, 12, 10, 8};

  sop_array u_sop_array (
    .in_i (in_i), .fb_i (fb_i), .fuse_i (fuse),
    .sum_o (sum_o), .oe_o (oe_o),
    .areset_term_o (ar_o), .preset_term_o (sp_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Behavioural model of one row
  function automatic bit m_row(int r);
    bit res;
    bit s;
    res = 1'b1;
    for (int c = 0; c < NCOL; c++) begin
      if (fuse[r*NCOL + c]) begin
        s = (c/2 < 12) ? in_i[c/2] : fb_i[c/2 - 12];
        res = res & ((c % 2 == 0) ? s : ~s);
      end
    end
    return res;
  endfunction

  function automatic logic [9:0] m_sum();
    logic [9:0] v;
    int base;
    base = 0;
    for (int k = 0; k < 10; k++) begin
      v[k] = 1'b0;
      for (int t = 0; t < grp_cnt[k]; t++) v[k] = v[k] | m_row(base + t);
      base += grp_cnt[k];
    end
    return v;
  endfunction

  function automatic logic [9:0] m_oe();
    logic [9:0] v;
    for (int k = 0; k < 10; k++) v[k] = m_row(120 + k);
    return v;
  endfunction

  task automatic chk(input string tag, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk({tag, " sum R6"},  sum_o, m_sum());
    chk({tag, " oe R7"},   oe_o,  m_oe());
    chk({tag, " ar R8"},   {9'd0, ar_o}, {9'd0, m_row(130)});
    chk({tag, " sp R8"},   {9'd0, sp_o}, {9'd0, m_row(131)});
  endtask

  task automatic set_conn(int r, int c);
    fuse[r*NCOL + c] = 1'b1;
  endtask

  initial begin
    wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 100000) begin
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected<100000", wd);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    checks = 0;
    errors = 0;
    rst_n  = 1'b0;
    in_i   = '0;
    fb_i   = '0;
    fuse   = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R3: erased configuration, every term high
    @(negedge clk);
    chk("R3 erased sum", sum_o, 10'h3FF);
    chk("R3 erased oe", oe_o, 10'h3FF);
    chk("R3 erased globals", {8'd0, ar_o, sp_o}, 10'd3);

    // R1/R2: single literals on the reset and preset rows
    @(posedge clk); #1;
    set_conn(130, 2*12);      // feedback 0, true
    set_conn(131, 2*3 + 1);   // input 3, inverted
    fb_i = 10'h001; in_i = 12'h008;
    @(negedge clk);
    chk("R1 fb0 true on reset row", {9'd0, ar_o}, 10'd1);
    chk("R1 in3 inverted on preset row", {9'd0, sp_o}, 10'd0);
    @(posedge clk); #1;
    fb_i = 10'h000; in_i = 12'h000;
    @(negedge clk);
    chk("R9 same-cycle follow reset row", {9'd0, ar_o}, 10'd0);
    chk("R2 preset row inverted literal", {9'd0, sp_o}, 10'd1);

    // R4: both polarities of one signal
    @(posedge clk); #1;
    fuse = '0;
    set_conn(131, 10); set_conn(131, 11);
    in_i = 12'h020;
    @(negedge clk);
    chk("R4 conflict low (in5=1)", {9'd0, sp_o}, 10'd0);
    @(posedge clk); #1;
    in_i = 12'h000;
    @(negedge clk);
    chk("R4 conflict low (in5=0)", {9'd0, sp_o}, 10'd0);

    // R5/R6: all sum rows forced low, then open single rows at group edges
    @(posedge clk); #1;
    fuse = '0;
    for (int r = 0; r < 120; r++) begin set_conn(r, 0); set_conn(r, 1); end
    @(negedge clk);
    chk("R6 all groups low", sum_o, 10'h000);
    @(posedge clk); #1;
    fuse[59*NCOL +: NCOL] = '0;   // last row of group 4 (rows 44..59)
    @(negedge clk);
    chk("R5 row 59 belongs to output 4", sum_o, 10'h010);
    @(posedge clk); #1;
    fuse[59*NCOL +: NCOL] = '0;
    set_conn(59, 0); set_conn(59, 1);
    fuse[60*NCOL +: NCOL] = '0;   // first row of group 5
    fuse[119*NCOL +: NCOL] = '0;  // last row of group 9
    fuse[7*NCOL +: NCOL] = '0;    // last row of group 0
    @(negedge clk);
    chk("R5 rows 7/60/119 to outputs 0/5/9", sum_o, 10'h221);
    chk("R7 enable rows blank", oe_o, 10'h3FF);

    // R7: enable row literal
    @(posedge clk); #1;
    set_conn(123, 2*20);          // output 3 enable = fb_i[8]
    fb_i = 10'h000;
    @(negedge clk);
    chk("R7 enable row 123 to oe_o[3]", oe_o, 10'h3F7);

    // Random sparse configurations compared against the model
    for (int v = 0; v < 300; v++) begin
      @(posedge clk); #1;
      if (v % 10 == 0) begin
        fuse = '0;
        for (int r = 0; r < NROW; r++) begin
          if ($urandom_range(3, 0) != 0) begin
            int n;
            n = $urandom_range(3, 1);
            for (int j = 0; j < n; j++) set_conn(r, $urandom_range(NCOL-1, 0));
          end
        end
      end
      in_i = 12'($urandom);
      fb_i = 10'($urandom);
      @(negedge clk);
      compare_all("R9 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule